// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block turns one load-multiple or store-multiple request into a stream of word accesses. The caller presents a base address, a 16-bit mask of registers, one of four walk modes and a writeback request, then pulses start. The block then emits one access per accepted cycle. Each access carries the register index and the word address that register maps to. The lowest-numbered register always sits at the lowest address.

The consumer paces the stream with a ready input. The final access is marked with a last strobe. One cycle after that access is accepted, a done pulse appears together with the updated base value, which is flagged valid only when writeback was requested. A separate flag reports whether register 15 was in the mask, so that the caller can treat the transfer as a change of control flow.

Top module: `blk_xfer_seq`

## Requirements
- R1: While reset is held and right after it, busy_o, valid_o, done_o, wb_valid_o and pc_in_list_o are all 0.
- R2: Mode code 2'b01 (ascending, address used before stepping): the first access uses the base address.
- R3: Mode code 2'b11 (ascending, step before use): the first access uses base+4.
- R4: Mode code 2'b00 (descending, use then step): the first access uses base-4n+4, where n is the number of set mask bits.
- R5: Mode code 2'b10 (descending, step then use): the first access uses base-4n.
- R6: In every mode, accesses go in ascending register order (mask bit 0 upward), and each address is 4 above the previous one.
- R7: While valid_o is 1 and ready_i is 0, the access on the outputs holds unchanged. One access is consumed on each cycle in which both are 1.
- R8: last_o is 1 only on the final access. done_o is a single-cycle pulse in the cycle after that access is accepted, and valid_o is then 0.
- R9: When writeback is requested and n>0, wb_valid_o pulses with done_o and wb_addr_o is base+4n for ascending modes and base-4n for descending modes. Without the request, wb_valid_o stays 0.
- R10: An all-zero mask gives a done_o pulse in the cycle after start, with no access and wb_valid_o at 0.
- R11: pc_in_list_o equals mask bit 15 as captured at start, and is held until the next accepted start.
- R12: addr_o bits [1:0] are always 0, even for an unaligned base.
- R13: A start pulse while busy_o is 1 is ignored. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sequence when idle |
| base_i | input | 32 | Base byte address |
| reg_list_i | input | 16 | Register mask, bit i selects register i |
| mode_i | input | 2 | Bit 0 = ascending, bit 1 = step before use |
| wb_en_i | input | 1 | Request base writeback |
| ready_i | input | 1 | Consumer accepts the current access |
| busy_o | output | 1 | Sequence in progress |
| valid_o | output | 1 | An access is presented |
| reg_idx_o | output | 4 | Register index of the access |
| addr_o | output | 32 | Word-aligned address of the access |
| last_o | output | 1 | Final access of the sequence |
| done_o | output | 1 | Single-cycle completion pulse |
| wb_valid_o | output | 1 | Writeback value is to be applied |
| wb_addr_o | output | 32 | Updated base value |
| pc_in_list_o | output | 1 | Register 15 is in the captured mask |

## Verification
A wrong remaining-mask or address register shows up at the very next presented access, either as a skipped or repeated register index or as an address that is not 4 above the previous one. The bench therefore compares every access of every sequence, including cycles stalled by ready, against an index and address computed from the mask alone. A wrong start-address or writeback calculation is visible on the first access, and on wb_addr_o at the done pulse. A stray sequencing state shows as a missing or doubled done pulse, or as valid_o staying high one cycle after last_o.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  // bit0: ascending, bit1: step before use
  typedef enum logic [1:0] {
    MODE_DEC_AFTER  = 2'b00,
    MODE_INC_AFTER  = 2'b01,
    MODE_DEC_BEFORE = 2'b10,
    MODE_INC_BEFORE = 2'b11
  } walk_mode_e;

  localparam int unsigned WORD_SHIFT = 2;
endpackage

// File: rtl/blk_bit_count.sv
module blk_bit_count #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned CNT_W = $clog2(IN_W + 1)
) (
  input  logic [IN_W-1:0]  vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < IN_W; i++) cnt_o = cnt_o + CNT_W'(vec_i[i]);
  end
endmodule

// File: rtl/blk_low_pick.sv
module blk_low_pick #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned IDX_W = $clog2(IN_W)
) (
  input  logic [IN_W-1:0]  vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [IN_W-1:0]  rest_o,
  output logic             one_left_o
);
  logic [IN_W-1:0] low_oh;

  assign low_oh     = vec_i & (~vec_i + IN_W'(1));
  assign rest_o     = vec_i & ~low_oh;
  assign one_left_o = (vec_i != '0) && (rest_o == '0);

  // one-hot to binary, OR of matching positions
  genvar b;
  generate
    for (b = 0; b < IDX_W; b++) begin : g_enc
      logic [IN_W-1:0] sel;
      for (genvar i = 0; i < IN_W; i++) begin : g_sel
        assign sel[i] = low_oh[i] & ((i >> b) & 1) == 1;
      end
      assign idx_o[b] = |sel;
    end
  endgenerate
endmodule

// File: rtl/blk_addr_plan.sv
module blk_addr_plan
  import blk_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 5
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  walk_mode_e        mode_i,
  output logic [ADDR_W-1:0] first_o,
  output logic [ADDR_W-1:0] wb_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << WORD_SHIFT;

  logic [ADDR_W-1:0] span;
  logic              inc, pre;

  assign span = ADDR_W'(cnt_i) << WORD_SHIFT;
  assign inc  = mode_i[0];
  assign pre  = mode_i[1];

  always_comb begin
    if (inc) begin
      first_o = pre ? base_i + STEP : base_i;
      wb_o    = base_i + span;
    end else begin
      first_o = pre ? base_i - span : base_i - span + STEP;
      wb_o    = base_i - span;
    end
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LIST_W = 16,
  localparam int unsigned IDX_W = $clog2(LIST_W),
  localparam int unsigned CNT_W = $clog2(LIST_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LIST_W-1:0] reg_list_i,
  input  logic [1:0]        mode_i,
  input  logic              wb_en_i,
  input  logic              ready_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              done_o,
  output logic              wb_valid_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic              pc_in_list_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << WORD_SHIFT;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << WORD_SHIFT) - ADDR_W'(1));

  logic              busy_q, done_q, wbv_q, wb_en_q, pc_q;
  logic [LIST_W-1:0] rem_q;
  logic [ADDR_W-1:0] addr_q, wb_addr_q;

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] first_addr, wb_value;
  logic [LIST_W-1:0] rem_next;
  logic              one_left;
  logic [IDX_W-1:0]  cur_idx;
  logic              take_start, take_xfer;

  blk_bit_count #(.IN_W(LIST_W), .CNT_W(CNT_W)) u_cnt (
    .vec_i (reg_list_i),
    .cnt_o (cnt)
  );

  blk_addr_plan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_plan (
    .base_i  (base_i),
    .cnt_i   (cnt),
    .mode_i  (walk_mode_e'(mode_i)),
    .first_o (first_addr),
    .wb_o    (wb_value)
  );

  blk_low_pick #(.IN_W(LIST_W), .IDX_W(IDX_W)) u_pick (
    .vec_i      (rem_q),
    .idx_o      (cur_idx),
    .rest_o     (rem_next),
    .one_left_o (one_left)
  );

  assign take_start = start_i && !busy_q;
  assign take_xfer  = busy_q && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      wbv_q     <= 1'b0;
      wb_en_q   <= 1'b0;
      pc_q      <= 1'b0;
      rem_q     <= '0;
      addr_q    <= '0;
      wb_addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      wbv_q  <= 1'b0;
      if (take_start) begin
        pc_q    <= reg_list_i[LIST_W-1];
        wb_en_q <= wb_en_i;
        if (reg_list_i == '0) begin
          done_q    <= 1'b1;
          wb_addr_q <= base_i;
        end else begin
          busy_q    <= 1'b1;
          rem_q     <= reg_list_i;
          addr_q    <= first_addr;
          wb_addr_q <= wb_en_i ? wb_value : base_i;
        end
      end else if (take_xfer) begin
        rem_q  <= rem_next;
        addr_q <= addr_q + STEP;
        if (one_left) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          wbv_q  <= wb_en_q;
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign valid_o      = busy_q;
  assign reg_idx_o    = cur_idx;
  assign addr_o       = addr_q & ALIGN_MASK;
  assign last_o       = busy_q && one_left;
  assign done_o       = done_q;
  assign wb_valid_o   = wbv_q;
  assign wb_addr_o    = wb_addr_q;
  assign pc_in_list_o = pc_q;
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_o,
  input logic              ready_i,
  input logic              last_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [IDX_W-1:0]  reg_idx_o,
  input logic              done_o,
  input logic              wb_valid_o
);
  p_addr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !last_o |=> valid_o && addr_o == $past(addr_o) + ADDR_W'(4));

  p_idx_up_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !last_o |=> reg_idx_o > $past(reg_idx_o));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(reg_idx_o));

  p_last_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && last_o |=> done_o && !valid_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_wb_with_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> done_o);

  p_align_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> addr_o[1:0] == 2'b00);
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_o    (valid_o),
  .ready_i    (ready_i),
  .last_o     (last_o),
  .addr_o     (addr_o),
  .reg_idx_o  (reg_idx_o),
  .done_o     (done_o),
  .wb_valid_o (wb_valid_o)
);

// File: tb/tb_blk_xfer_seq.sv
module tb_blk_xfer_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] reg_list_i = '0;
  logic [1:0]  mode_i = '0;
  logic        wb_en_i = 1'b0;
  logic        ready_i = 1'b0;
  logic        busy_o, valid_o, last_o, done_o, wb_valid_o, pc_in_list_o;
  logic [3:0]  reg_idx_o;
  logic [31:0] addr_o, wb_addr_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10ns clk_i = ~clk_i;

  blk_xfer_seq dut (
    .clk_i, .rst_ni, .start_i, .base_i, .reg_list_i, .mode_i, .wb_en_i, .ready_i,
    .busy_o, .valid_o, .reg_idx_o, .addr_o, .last_o, .done_o, .wb_valid_o,
    .wb_addr_o, .pc_in_list_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int nth_bit(logic [15:0] l, int k);
    int c = 0;
    for (int i = 0; i < 16; i++)
      if (l[i]) begin
        if (c == k) return i;
        c++;
      end
    return -1;
  endfunction

  // mode: 00 dec-after, 01 inc-after, 10 dec-before, 11 inc-before
  task automatic run_xfer(input logic [31:0] base, input logic [15:0] list,
                          input logic [1:0] mode, input bit wb, input bit stall,
                          input int inject, input string req);
    int n = 0;
    int k = 0;
    int cyc = 0;
    logic [31:0] lo, exp_wb, exp_a;
    for (int i = 0; i < 16; i++) n += int'(list[i]);
    case (mode)
      2'b01:   lo = base;
      2'b11:   lo = base + 32'd4;
      2'b00:   lo = base - 32'(4 * n) + 32'd4;
      default: lo = base - 32'(4 * n);
    endcase
    exp_wb = mode[0] ? base + 32'(4 * n) : base - 32'(4 * n);
    @(negedge clk_i);
    base_i = base; reg_list_i = list; mode_i = mode; wb_en_i = wb; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(pc_in_list_o == list[15], "R11", "pc flag", 32'(pc_in_list_o), 32'(list[15]));
    while (k < n && cyc < 200) begin
      ready_i = stall ? (cyc % 2 == 1) : 1'b1;
      if (cyc == inject) begin
        start_i = 1'b1; base_i = 32'h0; reg_list_i = 16'hffff; mode_i = 2'b10;
      end else start_i = 1'b0;
      exp_a = (lo + 32'(4 * k)) & 32'hffff_fffc;
      chk(valid_o === 1'b1, req, "valid", 32'(valid_o), 32'd1);
      chk(32'(reg_idx_o) == 32'(nth_bit(list, k)), (inject >= 0) ? "R13 R6" : "R6",
          "reg index", 32'(reg_idx_o), 32'(nth_bit(list, k)));
      chk(addr_o == exp_a, (k == 0) ? req : "R6", "address", addr_o, exp_a);
      chk(addr_o[1:0] == 2'b00, "R12", "alignment", 32'(addr_o[1:0]), 32'd0);
      chk(last_o == (k == n - 1), "R8", "last", 32'(last_o), 32'(k == n - 1));
      if (ready_i) k++;
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0;
    ready_i = 1'b0;
    chk(done_o === 1'b1, "R8", "done pulse", 32'(done_o), 32'd1);
    chk(valid_o === 1'b0, "R8", "valid after last", 32'(valid_o), 32'd0);
    chk(wb_valid_o === wb, "R9", "wb valid", 32'(wb_valid_o), 32'(wb));
    if (wb) chk(wb_addr_o == exp_wb, "R9", "wb value", wb_addr_o, exp_wb);
    @(negedge clk_i);
    chk(done_o === 1'b0, "R8", "done single cycle", 32'(done_o), 32'd0);
    chk(busy_o === 1'b0, "R13", "idle after run", 32'(busy_o), 32'd0);
  endtask

  task automatic test_reset;
    chk(busy_o === 1'b0 && valid_o === 1'b0, "R1", "busy/valid in reset",
        {30'd0, busy_o, valid_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(done_o === 1'b0 && wb_valid_o === 1'b0 && pc_in_list_o === 1'b0, "R1",
        "done/wb/pc after reset", {29'd0, done_o, wb_valid_o, pc_in_list_o}, 32'd0);
  endtask

  task automatic test_empty;
    @(negedge clk_i);
    base_i = 32'h5000; reg_list_i = 16'h0; mode_i = 2'b01; wb_en_i = 1'b1; start_i = 1'b1;
    ready_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o === 1'b1, "R10", "empty done", 32'(done_o), 32'd1);
    chk(valid_o === 1'b0, "R10", "empty no access", 32'(valid_o), 32'd0);
    chk(wb_valid_o === 1'b0, "R10", "empty no writeback", 32'(wb_valid_o), 32'd0);
    chk(pc_in_list_o === 1'b0, "R11", "pc flag cleared", 32'(pc_in_list_o), 32'd0);
    @(negedge clk_i);
    chk(done_o === 1'b0 && valid_o === 1'b0, "R10", "empty quiet after",
        {30'd0, done_o, valid_o}, 32'd0);
    ready_i = 1'b0;
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    test_reset();
    run_xfer(32'h0000_1000, 16'h00f0, 2'b01, 1'b1, 1'b0, -1, "R2");
    run_xfer(32'h0000_2000, 16'h8421, 2'b11, 1'b0, 1'b0, -1, "R3");
    run_xfer(32'h0000_3000, 16'h0013, 2'b00, 1'b1, 1'b1, -1, "R4");
    run_xfer(32'h0001_0000, 16'hffff, 2'b10, 1'b1, 1'b1, -1, "R5");
    run_xfer(32'h0000_4002, 16'h0100, 2'b10, 1'b1, 1'b0, -1, "R12");
    run_xfer(32'h0000_6000, 16'h0a0c, 2'b11, 1'b1, 1'b1, -1, "R7");
    test_empty();
    run_xfer(32'h0000_7000, 16'h00ff, 2'b01, 1'b1, 1'b0, 2, "R13");
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule